// File: doc/BRIEF.md
# Shift-Scaled Ladder Noise Shaper

This block turns a stream of signed 16-bit oversampled samples into a one-bit stream whose running density follows the input. Typical use is the digital front of a one-bit converter: an upstream rate-raising filter hands it one sample per oversampled clock, and the bit it emits drives a simple switch and an analog smoothing filter.

The loop filter is a ladder of lossless discrete integrators. Odd stages update from their registered neighbour, and even stages update from the neighbour's freshly computed value. Every gain in the loop is an arithmetic right shift, so the block has no multiplier. The first stage integrates the input minus the fed-back full-scale value. Later pairs of stages are coupled by a shifted negative feedback that forms a resonator. The one-bit decision is taken on the input plus a shift-weighted sum of all stage states. Because the input goes to the decision point directly as well as into the first stage, the signal passes with unity gain and only shaped noise is added. The order, guard width and all shift amounts are parameters. The default is 4th order, tuned for an oversampling ratio of 16.

Top module: `dsm_ladder_top`

## Requirements
- R1: Each cycle with `in_valid` high produces exactly one output bit, presented with `out_valid` high in the next cycle, in input order.
- R2: The output bit is 1 when the decision sum (input plus the weighted stage states) is greater than or equal to zero, and 0 otherwise. Right after reset all states are zero, so the first bit is 1 for a sample whose sign bit (bit 15) is 0 and 0 for a negative sample.
- R3: A cycle with `in_valid` low changes no state. In the next cycle `out_valid` is low and `out_bit` keeps its last value, so gaps in the input stream do not alter the bit sequence.
- R4: A synchronous reset clears every integrator and drives `out_bit` and `out_valid` to 0. A given input sequence applied after any reset yields the same bit sequence.
- R5: With a constant input of +8192 (a quarter of full scale, where a bit of 1 stands for +32768 and 0 for -32768), the mean of the bits over 4096 samples matches the input within 1 % of full scale: between 2539 and 2580 ones.
- R6: With a constant input of -16384, 4096 samples hold between 1004 and 1044 ones.
- R7: With a constant zero input, 4096 samples hold between 2028 and 2068 ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampled clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` for this cycle |
| in_sample | input | 16 | Two's complement input sample |
| out_bit | output | 1 | Modulated bit, 1 = plus full scale |
| out_valid | output | 1 | High for the cycle carrying a new bit |

## Verification
A fixed deterministic ramp pattern is applied once to capture a bit sequence. The same pattern is then replayed with idle gaps that carry junk data, which separates a design that truly freezes on idle cycles from one that leaks junk into its states. A replay after a fresh reset shows whether any state survives the reset. Single first samples of each sign probe the decision threshold at exactly zero state. Long constant inputs at a positive quarter, a negative half and zero test the density against the input, which catches sign, feedback-level and integration errors.

// File: rtl/dsm_pkg.sv
`timescale 1ns/1ps
package dsm_pkg;

    // Registered output of the modulator.
    typedef struct packed {
        logic valid;
        logic level;
    } dsm_out_t;

endpackage

// File: rtl/dsm_ldi_stage.sv
`timescale 1ns/1ps
module dsm_ldi_stage #(
    parameter int unsigned W = 28
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic signed [W-1:0] add_term,
    input  logic signed [W-1:0] sub_term,
    output logic signed [W-1:0] acc_q,
    output logic signed [W-1:0] acc_d
);

    localparam int unsigned XW = W + 2;
    localparam logic signed [XW-1:0] LIM_HI = $signed({3'b000, {(W-1){1'b1}}});
    localparam logic signed [XW-1:0] LIM_LO = $signed({3'b111, {(W-1){1'b0}}});

    logic signed [XW-1:0] raw_sum;

    always_comb begin
        raw_sum = XW'(acc_q) + XW'(add_term) - XW'(sub_term);
        acc_d   = acc_q;
        if (en) begin
            if (raw_sum > LIM_HI) begin
                acc_d = LIM_HI[W-1:0];
            end else if (raw_sum < LIM_LO) begin
                acc_d = LIM_LO[W-1:0];
            end else begin
                acc_d = raw_sum[W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(acc_q)); // R3
    AST_STAGE_CLEAR: assert property (@(posedge clk) rst |=> (acc_q == '0)); // R4

endmodule

// File: rtl/dsm_sign_quant.sv
`timescale 1ns/1ps
module dsm_sign_quant #(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned W     = 28,
    parameter int unsigned ORDER = 4,
    parameter int unsigned TAP_SHIFT [ORDER] = '{0, 2, 4, 8}
) (
    input  logic signed [IN_W-1:0] sample,
    input  logic signed [W-1:0]    states [ORDER],
    output logic                   decide
);

    localparam int unsigned SW = W + $clog2(ORDER + 1) + 1;

    logic signed [SW-1:0] total;

    always_comb begin
        total = SW'(sample);
        for (int k = 0; k < ORDER; k++) begin
            total = total + SW'(states[k] >>> TAP_SHIFT[k]);
        end
        decide = ~total[SW-1];
    end

endmodule

// File: rtl/dsm_ladder_top.sv
`timescale 1ns/1ps
module dsm_ladder_top #(
    parameter int unsigned IN_W     = 16,
    parameter int unsigned GUARD    = 12,
    parameter int unsigned ORDER    = 4,
    parameter int unsigned FWD_SHIFT [ORDER-1] = '{1, 2, 3},
    parameter int unsigned TAP_SHIFT [ORDER]   = '{0, 2, 4, 8},
    parameter int unsigned FB_SHIFT = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    output logic                   out_bit,
    output logic                   out_valid
);
    import dsm_pkg::*;

    localparam int unsigned W = IN_W + GUARD;
    localparam logic signed [W-1:0] FS_POS = $signed({{GUARD{1'b0}}, 1'b1, {(IN_W-1){1'b0}}});
    localparam logic signed [W-1:0] FS_NEG = -FS_POS;

    logic                decide;
    logic signed [W-1:0] u_wide;
    logic signed [W-1:0] st_q [ORDER];
    dsm_out_t            out_d;
    dsm_out_t            out_q;

    assign u_wide = W'(in_sample);

    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        logic signed [W-1:0] add_t;
        logic signed [W-1:0] sub_t;
        logic signed [W-1:0] sq;
        logic signed [W-1:0] sd;

        if (k == 0) begin : g_head
            assign add_t = u_wide - (decide ? FS_POS : FS_NEG);
        end else if (k % 2 == 1) begin : g_fresh
            // even stage (1-based): takes the neighbour's value being written now
            assign add_t = g_stage[k-1].sd >>> FWD_SHIFT[k-1];
        end else begin : g_held
            // odd stage (1-based): takes the neighbour's registered value
            assign add_t = g_stage[k-1].sq >>> FWD_SHIFT[k-1];
        end

        if (k >= 2 && k + 1 < ORDER) begin : g_res
            assign sub_t = st_q[k+1] >>> FB_SHIFT;
        end else begin : g_open
            assign sub_t = '0;
        end

        dsm_ldi_stage #(.W(W)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .en       (in_valid),
            .add_term (add_t),
            .sub_term (sub_t),
            .acc_q    (sq),
            .acc_d    (sd)
        );

        assign st_q[k] = sq;
    end

    dsm_sign_quant #(
        .IN_W      (IN_W),
        .W         (W),
        .ORDER     (ORDER),
        .TAP_SHIFT (TAP_SHIFT)
    ) u_quant (
        .sample (in_sample),
        .states (st_q),
        .decide (decide)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.level = decide;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_bit   = out_q.level;
    assign out_valid = out_q.valid;

    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(out_bit))); // R3
    AST_FIRST_SIGN: assert property (@(posedge clk) disable iff (rst) ($past(rst) && in_valid) |=> (out_bit == !$past(in_sample[IN_W-1]))); // R2
    AST_RESET_OUT: assert property (@(posedge clk) rst |=> (!out_valid && !out_bit)); // R4

endmodule

// File: tb/sim_dsm_ladder_top.sv
`timescale 1ns/1ps
module sim_dsm_ladder_top;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_bit;
    logic               out_valid;

    always #2.5 clk = ~clk;

    dsm_ladder_top u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_bit   (out_bit),
        .out_valid (out_valid)
    );

    typedef struct {
        logic  level;
        string req;
    } exp_t;

    exp_t  exp_q[$];
    logic  rec [300];
    int    rec_n = 0;
    int    mode = 0;      // 0 compare with queue, 1 record, 2 count ones
    int    ones = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    logic  prev_v = 1'b0;
    logic  have_bit = 1'b0;
    logic  last_bit = 1'b0;
    bit    done = 1'b0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: scoreboard pop, recording, counting, idle hold (R3)
    always @(negedge clk) begin
        if (rst) begin
            have_bit = 1'b0;
        end else if (out_valid) begin
            if (mode == 0) begin
                if (exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_bit === e.level, e.req, "output bit", int'(out_bit), int'(e.level));
                end else begin
                    check(1'b0, "R1", "output with nothing expected", 1, 0);
                end
            end else if (mode == 1) begin
                if (rec_n < 300) rec[rec_n] = out_bit;
                rec_n++;
            end else begin
                ones += int'(out_bit);
            end
            have_bit = 1'b1;
            last_bit = out_bit;
        end else if (have_bit) begin
            check(out_bit === last_bit, "R3", "bit held on idle cycle", int'(out_bit), int'(last_bit));
        end
    end

    function automatic logic signed [15:0] pat(input int i);
        return 16'(((i * 977) % 20000) - 10000);
    endfunction

    task automatic drive(input logic signed [15:0] s, input logic v);
        @(negedge clk);
        check(out_valid === prev_v, "R1", "out_valid one cycle after in_valid", int'(out_valid), int'(prev_v));
        in_valid  = v;
        in_sample = s;
        prev_v    = v;
    endtask

    task automatic push(input logic b, input string req);
        exp_t e;
        e.level = b;
        e.req   = req;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(16'sh1234, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        prev_v = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && out_bit === 1'b0, "R4", "outputs cleared in reset",
              int'({out_valid, out_bit}), 0);
        rst = 1'b0;
    endtask

    task automatic dc_run(input logic signed [15:0] lvl, input int lo, input int hi, input string req);
        do_reset();
        mode = 2;
        ones = 0;
        for (int i = 0; i < 4096; i++) drive(lvl, 1'b1);
        idle(3);
        check(ones >= lo && ones <= hi, req, "ones in 4096 samples", ones, (lo + hi) / 2);
        mode = 0;
    endtask

    initial begin
        // first bit after reset follows the input sign (R2)
        do_reset();
        mode = 0;
        push(1'b0, "R2");
        drive(-16'sd100, 1'b1);
        idle(3);
        do_reset();
        push(1'b1, "R2");
        drive(16'sd0, 1'b1);
        idle(3);
        do_reset();
        push(1'b1, "R2");
        drive(16'sd12345, 1'b1);
        idle(3);

        // reference run with an unbroken stream
        do_reset();
        mode = 1;
        rec_n = 0;
        for (int i = 0; i < 300; i++) drive(pat(i), 1'b1);
        idle(3);
        mode = 0;
        check(rec_n == 300, "R1", "one bit per valid sample", rec_n, 300);

        // same stream with idle gaps carrying junk (R3)
        do_reset();
        for (int i = 0; i < 300; i++) begin
            push(rec[i], "R3");
            drive(pat(i), 1'b1);
            if (i % 7 == 3) begin
                drive(16'(16'sh7abc ^ i), 1'b0);
                drive(-16'sd32768, 1'b0);
            end
        end
        idle(3);
        check(exp_q.size() == 0, "R3", "all gapped outputs seen", exp_q.size(), 0);

        // same stream after a fresh reset (R4)
        do_reset();
        for (int i = 0; i < 300; i++) begin
            push(rec[i], "R4");
            drive(pat(i), 1'b1);
        end
        idle(3);
        check(exp_q.size() == 0, "R4", "all replayed outputs seen", exp_q.size(), 0);

        // bit density against constant inputs
        dc_run(16'sd8192, 2539, 2580, "R5");
        dc_run(-16'sd16384, 1004, 1044, "R6");
        dc_run(16'sd0, 2028, 2068, "R7");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule